// File: doc/BRIEF.md
# Two-wire command register slave

This block is the serial front end of a small register bank. It listens on a two-wire bus (clock SCL, open-drain data SDA), both oversampled by a fast system clock. Each transfer opens with a start condition and a first byte. That byte carries a fixed 4-bit device code, a 3-bit command that picks one of eight register targets, and a direction bit. The block then moves data bytes between the bus and the selected target. The target decides how many bytes a burst carries: seven for the full calendar word, three for the hour-minute-second word and for each alarm word, and one for the others.

The register bank itself sits outside the block. On a write, the block collects every byte of the target and only then hands over the whole word with a single strobe, so a half-finished write never lands. On a read, the block pulses a grant strobe, takes a snapshot of the word the bank presents for the selected target, and shifts it out LSB first, starting with the byte at bits 7:0. Two duties of the first status target live here because they concern the bus: its bit 0 always reads back as 0, and writing a 1 to that bit raises an initialise strobe for the bank. The grant strobe lets the bank clear its read-to-clear flags.

Top module: `twowire_cmd_slave`

## Requirements
- R1: A start is SDA falling while SCL is high; a stop is SDA rising while SCL is high. Out of reset and after a stop the block drives nothing and raises no strobe until the next start.
- R2: The first byte is received MSB first as device code 0110 (bits 7:4), command C2..C0 (bits 3:1) and direction (bit 0, 1 = read). A matching code is acknowledged by pulling SDA low for the 9th clock.
- R3: A first byte with any other device code is not acknowledged, and the block ignores the bus until the next start.
- R4: Commands select targets and burst lengths: 000 status 1 (1 byte), 001 status 2 (1), 010 full time (7), 011 hour-minute-second (3), 100 alarm 1 (3), 101 alarm 2 (3), 110 rate adjust (1), 111 free storage (1). `tgt_sel` carries the command during each strobe.
- R5: Write data bytes are received LSB first, and each byte up to the burst length is acknowledged. A byte beyond the burst length is not acknowledged and changes nothing.
- R6: A write is handed over as one word with exactly one `wr_stb` pulse, only after the last byte of the burst is acknowledged. Byte k of the burst sits at `wr_data[8k+7:8k]`, so the full-time word starts with the year byte. A write cut short by a stop or a start hands over nothing.
- R7: On a read, `rd_stb` pulses once as the first byte is acknowledged, and the block sends the snapshot of `rd_word` LSB first, byte 0 first. It sends the next byte only while the master acknowledges and the burst is not complete. A master no-acknowledge releases SDA for the rest of the transfer.
- R8: A stop in the middle of a read ends the transfer. SDA stays released until the next start.
- R9: Reads of status 1 return bit 0 as 0. A write to status 1 with bit 0 set raises `init_stb` together with its `wr_stb`.
- R10: A repeated start at any point restarts decoding of the first byte and drops any unfinished write.
- R11: `sda_oe` changes only while the sampled SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 = pull SDA low (open-drain drive) |
| tgt_sel | output | 3 | Command of the current transfer, selects the target |
| wr_stb | output | 1 | One-cycle pulse: `wr_data` holds a complete write word |
| wr_data | output | 56 | Written word, byte 0 in bits 7:0 |
| init_stb | output | 1 | One-cycle pulse: status 1 written with bit 0 set |
| rd_stb | output | 1 | One-cycle pulse: read granted, `rd_word` sampled |
| rd_word | input | 56 | Current word of the target named by `tgt_sel` |

## Verification
One write-then-read pass is made for every command. Each pass uses data whose bytes all differ, so it shows that byte order, LSB-first bit order, burst length and target selection are all correct. Further transfers use a wrong device code, a byte past the burst length, a write cut by a stop and one cut by a repeated start. These show which bytes are acknowledged, and whether a handover happens or is suppressed. Reads ended by an early no-acknowledge or by a stop after an acknowledged byte show that SDA is then released. A status 1 write with bit 0 set, followed by a read of it, checks both the initialise strobe and the masked bit.

// File: rtl/tw_pkg.sv
// Shared types and the command-to-burst-length rule for the two-wire slave.
package tw_pkg;
    localparam int TW_MAX_BYTES = 7;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_AACK, ST_WBYTE, ST_WACK, ST_RBYTE, ST_RACK, ST_WAIT
    } tw_state_e;

    // Number of data bytes moved for each command.
    function automatic logic [2:0] tw_burst_len(input logic [2:0] cmd);
        case (cmd)
            3'b010:                 return 3'd7;
            3'b011, 3'b100, 3'b101: return 3'd3;
            default:                return 3'd1;
        endcase
    endfunction
endpackage

// File: rtl/tw_line_sync.sv
// Synchronises one asynchronous bus line into clk.
// Assumes the line idles high; reset loads ones so no false edge appears.
module tw_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] q;

    // Shift the line through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '1;
        else        q <= {q[STAGES-2:0], din};
    end

    assign dout = q[STAGES-1];
endmodule

// File: rtl/tw_bus_events.sv
// Turns synchronised SCL/SDA levels into clock edges and start/stop events.
// Assumes both inputs come from tw_line_sync with equal depth.
module tw_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic scl_p, sda_p;

    // Remember the previous sampled levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    assign scl_rise = scl_s & ~scl_p;
    assign scl_fall = ~scl_s & scl_p;
    assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/twowire_cmd_slave.sv
// Two-wire command slave: decodes device code + command + direction, then
// bursts LSB-first data bytes to or from one of eight targets. Writes are
// handed over whole; reads come from a snapshot taken at grant.
// Assumes SCL is slower than clk by well over SYNC_STAGES+2 cycles per phase.
module twowire_cmd_slave
    import tw_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] DEV_CODE    = 4'b0110,
    localparam int        WORD_W      = 8 * TW_MAX_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [2:0]        tgt_sel,
    output logic              wr_stb,
    output logic [WORD_W-1:0] wr_data,
    output logic              init_stb,
    output logic              rd_stb,
    input  logic [WORD_W-1:0] rd_word
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

    tw_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .din(scl_i), .dout(scl_s));
    tw_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .din(sda_i), .dout(sda_s));
    tw_bus_events u_events (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev));

    tw_state_e         state;
    logic [2:0]        bitcnt;
    logic [7:0]        shreg;
    logic [2:0]        cmd;
    logic              rw;
    logic              ack_on;
    logic [2:0]        idx;
    logic [WORD_W-1:0] wbuf;
    logic [WORD_W-1:0] snap;
    logic [6:0]        txsh;
    logic [7:0]        addr_byte, data_byte;
    logic [2:0]        len;

    // Byte views of the shift register and burst length of the command.
    always_comb begin
        addr_byte = {shreg[6:0], sda_s};
        data_byte = {sda_s, shreg[7:1]};
        len       = tw_burst_len(cmd);
    end

    assign tgt_sel = cmd;

    // Protocol state machine: address, acknowledge, data in/out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;  bitcnt <= '0; shreg <= '0; cmd <= '0; rw <= 1'b0;
            ack_on <= 1'b0;    idx <= '0;    wbuf <= '0;  snap <= '0; txsh <= '0;
            sda_oe <= 1'b0;    wr_stb <= 1'b0; wr_data <= '0;
            init_stb <= 1'b0;  rd_stb <= 1'b0;
        end else begin
            wr_stb   <= 1'b0;
            rd_stb   <= 1'b0;
            init_stb <= 1'b0;
            if (start_ev) begin
                state <= ST_ADDR; bitcnt <= '0; sda_oe <= 1'b0; ack_on <= 1'b0;
            end else if (stop_ev) begin
                state <= ST_IDLE; sda_oe <= 1'b0; ack_on <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR: if (scl_rise) begin
                        shreg  <= addr_byte;
                        bitcnt <= bitcnt + 3'd1;
                        if (bitcnt == 3'd7) begin
                            if (addr_byte[7:4] == DEV_CODE) begin
                                cmd <= addr_byte[3:1]; rw <= addr_byte[0];
                                state <= ST_AACK; ack_on <= 1'b0;
                            end else begin
                                state <= ST_WAIT;
                            end
                        end
                    end
                    ST_AACK: if (scl_fall) begin
                        if (!ack_on) begin
                            sda_oe <= 1'b1; ack_on <= 1'b1; idx <= '0; wbuf <= '0;
                            if (rw) begin
                                rd_stb <= 1'b1;
                                snap   <= (cmd == 3'b000) ? {rd_word[WORD_W-1:1], 1'b0} : rd_word;
                            end
                        end else begin
                            ack_on <= 1'b0; bitcnt <= '0;
                            if (rw) begin
                                state <= ST_RBYTE; txsh <= snap[7:1];
                                sda_oe <= ~snap[0]; snap <= snap >> 8;
                            end else begin
                                state <= ST_WBYTE; sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_WBYTE: if (scl_rise) begin
                        shreg  <= data_byte;
                        bitcnt <= bitcnt + 3'd1;
                        if (bitcnt == 3'd7) begin
                            if (idx < len) begin
                                wbuf[{idx, 3'b000} +: 8] <= data_byte;
                                state <= ST_WACK; ack_on <= 1'b0;
                            end else begin
                                state <= ST_WAIT;
                            end
                        end
                    end
                    ST_WACK: if (scl_fall) begin
                        if (!ack_on) begin
                            sda_oe <= 1'b1; ack_on <= 1'b1;
                        end else begin
                            sda_oe <= 1'b0; ack_on <= 1'b0; bitcnt <= '0;
                            idx <= idx + 3'd1; state <= ST_WBYTE;
                            if (idx + 3'd1 == len) begin
                                wr_stb  <= 1'b1;
                                wr_data <= wbuf;
                                if (cmd == 3'b000 && wbuf[0]) init_stb <= 1'b1;
                            end
                        end
                    end
                    ST_RBYTE: if (scl_fall) begin
                        if (bitcnt == 3'd7) begin
                            sda_oe <= 1'b0; state <= ST_RACK;
                        end else begin
                            bitcnt <= bitcnt + 3'd1;
                            txsh   <= {1'b0, txsh[6:1]};
                            sda_oe <= ~txsh[0];
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            if (!sda_s && (idx + 3'd1 < len)) idx <= idx + 3'd1;
                            else                               state <= ST_WAIT;
                        end else if (scl_fall) begin
                            state <= ST_RBYTE; bitcnt <= '0; txsh <= snap[7:1];
                            sda_oe <= ~snap[0]; snap <= snap >> 8;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/tw_slave_chk.sv
// Property checker for twowire_cmd_slave, attached by bind below.
module tw_slave_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        sda_oe,
    input logic        scl_s,
    input logic        stop_ev,
    input logic        wr_stb,
    input logic        rd_stb,
    input logic        init_stb,
    input logic [2:0]  tgt_sel,
    input logic [55:0] wr_data
);
    // R11: the data drive only moves while SCL is sampled low.
    assert_oe_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !$past(scl_s));

    // R8: a stop always leaves SDA released.
    assert_stop_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !sda_oe);

    // R9: initialise only with a status 1 handover carrying bit 0 set.
    assert_init_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        init_stb |-> (wr_stb && tgt_sel == 3'b000 && wr_data[0]));

    // R7: a read grant never coincides with a write handover.
    assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_stb, rd_stb}));

    // R2: the read grant comes with the first-byte acknowledge drive.
    assert_grant_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> sda_oe);
endmodule

bind twowire_cmd_slave tw_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_s(scl_s), .stop_ev(stop_ev),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .init_stb(init_stb),
    .tgt_sel(tgt_sel), .wr_data(wr_data));

// File: tb/twowire_cmd_slave_tb.sv
// Bench: vector table write/read pass per command, then directed cases.
module twowire_cmd_slave_tb;
    localparam int Q = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_low = 1'b0;
    logic        sda_line;
    logic        sda_oe, wr_stb, init_stb, rd_stb;
    logic [2:0]  tgt_sel;
    logic [55:0] wr_data, rd_word;
    logic [55:0] mem [8];

    int total = 0, bad = 0, n_wr = 0, n_rd = 0, n_init = 0, n_viol = 0;
    logic [2:0]  last_sel = '0;
    logic [55:0] last_data = '0;
    logic        prev_oe = 1'b0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    assign sda_line = ~(m_low | sda_oe);
    assign rd_word  = mem[tgt_sel];

    twowire_cmd_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .tgt_sel(tgt_sel), .wr_stb(wr_stb), .wr_data(wr_data), .init_stb(init_stb),
        .rd_stb(rd_stb), .rd_word(rd_word));

    // Target model and strobe counters.
    always @(posedge clk) begin
        prev_oe <= sda_oe;
        if (rst_n && sda_oe != prev_oe && m_scl) n_viol <= n_viol + 1;
        if (wr_stb) begin
            n_wr <= n_wr + 1; last_sel <= tgt_sel; last_data <= wr_data;
            mem[tgt_sel] <= wr_data;
        end
        if (rd_stb)   n_rd <= n_rd + 1;
        if (init_stb) n_init <= n_init + 1;
    end

    // cmd[2:0], data[55:0]; byte 0 is sent first.
    localparam logic [58:0] VEC [8] = '{
        {3'b000, 56'h0000000000008C},
        {3'b001, 56'h0000000000003A},
        {3'b010, 56'h45591303170724},
        {3'b011, 56'h00000000302211},
        {3'b100, 56'h000000008A4203},
        {3'b101, 56'h00000000C35A06},
        {3'b110, 56'h000000000000B7},
        {3'b111, 56'h000000000000E1}
    };

    function automatic int blen(input logic [2:0] c);
        if (c == 3'b010) return 7;
        if (c == 3'b011 || c == 3'b100 || c == 3'b101) return 3;
        return 1;
    endfunction

    function automatic logic [55:0] keep(input logic [55:0] d, input int n);
        logic [55:0] m;
        m = (56'd1 << (8 * n)) - 56'd1;
        return d & m;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic m_start();
        m_scl = 1'b0; wq(); m_low = 1'b0; wq(); m_scl = 1'b1; wq();
        m_low = 1'b1; wq(); m_scl = 1'b0; wq();
    endtask

    task automatic m_stop();
        m_scl = 1'b0; wq(); m_low = 1'b1; wq(); m_scl = 1'b1; wq(); m_low = 1'b0; wq();
    endtask

    task automatic bit_out(input logic b);
        m_low = ~b; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0; wq();
    endtask

    task automatic bit_in(output logic b);
        m_low = 1'b0; wq(); m_scl = 1'b1; wq(); b = sda_line; wq(); m_scl = 1'b0; wq();
    endtask

    task automatic send_addr(input logic [3:0] code, input logic [2:0] c, input logic rw, output bit ack);
        logic [7:0] by;
        logic a;
        by = {code, c, rw};
        for (int i = 7; i >= 0; i--) bit_out(by[i]);
        bit_in(a);
        ack = ~a;
    endtask

    task automatic send_data(input logic [7:0] d, output bit ack);
        logic a;
        for (int i = 0; i < 8; i++) bit_out(d[i]);
        bit_in(a);
        ack = ~a;
    endtask

    task automatic recv_data(input bit give_ack, output logic [7:0] d);
        for (int i = 0; i < 8; i++) bit_in(d[i]);
        bit_out(~give_ack);
    endtask

    task automatic do_write(input logic [2:0] c, input logic [55:0] d, input int n, output bit all_ack);
        bit a;
        m_start();
        send_addr(4'b0110, c, 1'b0, a);
        all_ack = a;
        for (int i = 0; i < n; i++) begin
            send_data(d[i*8 +: 8], a);
            all_ack = all_ack & a;
        end
        m_stop();
        wq();
    endtask

    task automatic do_read(input logic [2:0] c, input int n, output logic [55:0] d, output bit ack);
        logic [7:0] b;
        d = '0;
        m_start();
        send_addr(4'b0110, c, 1'b1, ack);
        for (int i = 0; i < n; i++) begin
            recv_data(i != n - 1, b);
            d[i*8 +: 8] = b;
        end
        m_stop();
        wq();
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [55:0] rd;
        logic [55:0] exp;
        logic [7:0]  b8;
        logic        lb;
        bit          ok, a;
        int          w0, r0, i0;
        for (int i = 0; i < 8; i++) mem[i] = '0;

        repeat (5) @(negedge clk);
        chk(sda_oe == 1'b0 && wr_stb == 1'b0 && rd_stb == 1'b0 && init_stb == 1'b0,
            "R1 reset outputs idle", {sda_oe, wr_stb, rd_stb, init_stb}, 0);
        rst_n = 1'b1;
        wq();
        chk(sda_oe == 1'b0, "R1 idle after reset", sda_oe, 0);

        // Table walk: write each target, check handover, read it back.
        for (int v = 0; v < 8; v++) begin
            logic [2:0] c;
            int n;
            c = VEC[v][58:56];
            n = blen(c);
            w0 = n_wr; r0 = n_rd;
            do_write(c, VEC[v][55:0], n, ok);
            chk(ok, "R2 R5 address and data acknowledged", ok, 1);
            chk(n_wr == w0 + 1 && last_sel == c, "R4 R6 single handover to target",
                {n_wr - w0, last_sel}, {32'd1, c});
            chk(last_data == keep(VEC[v][55:0], n), "R6 word byte order", last_data, keep(VEC[v][55:0], n));
            do_read(c, n, rd, ok);
            exp = keep(VEC[v][55:0], n);
            chk(ok && n_rd == r0 + 1, "R7 read granted once", n_rd - r0, 1);
            chk(rd == exp, "R7 read data LSB first", rd, exp);
        end

        // R3: wrong device code is not acknowledged and later bytes are ignored.
        w0 = n_wr;
        m_start();
        send_addr(4'b0101, 3'b111, 1'b0, a);
        chk(!a, "R3 wrong code not acknowledged", a, 0);
        send_data(8'h00, a);
        chk(!a, "R3 ignored until next start", a, 0);
        m_stop(); wq();
        chk(n_wr == w0, "R3 no handover", n_wr - w0, 0);

        // R5: byte beyond the one-byte burst is refused.
        m_start();
        send_addr(4'b0110, 3'b111, 1'b0, a);
        send_data(8'h6C, a);
        chk(a, "R5 first byte acknowledged", a, 1);
        send_data(8'h93, a);
        chk(!a, "R5 extra byte not acknowledged", a, 0);
        m_stop(); wq();
        chk(last_sel == 3'b111 && last_data == 56'h6C, "R5 extra byte has no effect", last_data, 56'h6C);

        // R6: full-time write cut after 3 bytes hands nothing over.
        w0 = n_wr;
        do_write(3'b010, 56'h00000000ABCDEF, 3, ok);
        chk(n_wr == w0, "R6 partial write not handed over", n_wr - w0, 0);
        do_read(3'b010, 7, rd, ok);
        chk(rd == 56'h45591303170724, "R6 full-time word unchanged", rd, 56'h45591303170724);

        // R9: status 1 bit 0 written as 1 raises init, reads back as 0.
        i0 = n_init;
        do_write(3'b000, 56'h8D, 1, ok);
        chk(n_init == i0 + 1, "R9 init strobe on bit 0 write", n_init - i0, 1);
        do_read(3'b000, 1, rd, ok);
        chk(rd == 56'h8C, "R9 bit 0 reads as 0", rd, 56'h8C);

        // R7: early no-acknowledge releases SDA.
        m_start();
        send_addr(4'b0110, 3'b100, 1'b1, a);
        recv_data(1'b0, b8);
        chk(b8 == 8'h03, "R7 first alarm byte", b8, 8'h03);
        ok = 1'b1;
        for (int i = 0; i < 8; i++) begin bit_in(lb); ok = ok & lb; end
        chk(ok, "R7 released after no-acknowledge", ok, 1);
        m_stop(); wq();

        // R8: stop after an acknowledged byte of a 7-byte read.
        m_start();
        send_addr(4'b0110, 3'b010, 1'b1, a);
        recv_data(1'b1, b8);
        chk(b8 == 8'h24, "R8 year byte first", b8, 8'h24);
        m_stop(); wq();
        ok = 1'b1;
        for (int i = 0; i < 9; i++) begin bit_in(lb); ok = ok & lb; end
        chk(ok, "R8 SDA released after stop", ok, 1);
        do_read(3'b111, 1, rd, ok);
        chk(ok && rd == 56'h6C, "R8 next transfer after stop", rd, 56'h6C);

        // R10: repeated start in a full-time write restarts decoding.
        w0 = n_wr;
        m_start();
        send_addr(4'b0110, 3'b010, 1'b0, a);
        send_data(8'h11, a);
        send_data(8'h22, a);
        m_start();
        send_addr(4'b0110, 3'b111, 1'b0, a);
        chk(a, "R10 address after repeated start acknowledged", a, 1);
        send_data(8'h5E, a);
        m_stop(); wq();
        chk(n_wr == w0 + 1 && last_sel == 3'b111 && last_data == 56'h5E,
            "R10 only the new transfer handed over", {n_wr - w0, last_sel}, {32'd1, 3'b111});

        chk(n_viol == 0, "R11 drive moved only while SCL low", n_viol, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule